// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or dropped, judging only by its 48-bit destination address. The receive logic presents the six destination bytes together with a one-cycle strobe. A fixed number of cycles later the filter raises exactly one of two one-cycle outputs: keep or drop.

Individual addresses are compared against a programmed station address. Group (multicast) addresses are hashed with the Ethernet CRC-32 into one of 64 bins held in two 32-bit words. The all-ones address has its own reject control. A promiscuous control overrides every other rule. Software programs the station address, the hash words and the two control bits. They are expected to stay stable while frames are in flight.

The bus `dst_addr` carries byte 0 (the first byte on the wire) in bits 47:40 and byte 5 in bits 7:0. The block is a three-stage pipeline: it captures the address, then classifies it and computes the hash, then decides.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and until the first result, `keep` and `drop` are both low.
- R2: An individual address (bit 0 of byte 0, i.e. `dst_addr[40]`, clear) is kept only when all 48 bits equal the station address; otherwise it is dropped. The station address is formed from `sta_word_hi[15:8]` as byte 0, `sta_word_hi[7:0]` as byte 1, and `sta_word_lo[31:24]` down to `sta_word_lo[7:0]` as bytes 2 to 5.
- R3: A group address (`dst_addr[40]` set, not all ones) is kept exactly when its hash bin bit is set. The CRC-32 uses the reflected polynomial 0xEDB88320 and an initial value of all ones. It runs over bytes 0 to 5 in order, each byte least significant bit first, with no final inversion. If r is the resulting register, the bin index is {r[0],r[1],r[2],r[3],r[4],r[5]}. Index bit 5 picks `hash_word_hi` when 1 and `hash_word_lo` when 0. Index bits 4:0 pick the bit within that word.
- R4: The all-ones address is kept when `bcast_reject` is low and dropped when it is high. The hash words are not consulted for it.
- R5: When `promisc` is high, every strobed address is kept.
- R6: With both hash words all ones, every group address other than all ones is kept.
- R7: `keep` and `drop` are never high together, and each strobe produces exactly one of them for exactly one cycle.
- R8: The result for a strobe sampled at rising edge k appears after rising edge k+2 and lasts one cycle. Strobes on consecutive cycles each get their own result. No result appears without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dst_valid | input | 1 | One-cycle strobe: `dst_addr` holds a new destination address |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| sta_word_lo | input | 32 | Station address bytes 2..5 (byte 2 in 31:24) |
| sta_word_hi | input | 16 | Station address bytes 0..1 (byte 0 in 15:8) |
| hash_word_lo | input | 32 | Hash bins 0..31 |
| hash_word_hi | input | 32 | Hash bins 32..63 |
| bcast_reject | input | 1 | Drop frames sent to the all-ones address |
| promisc | input | 1 | Keep every frame |
| keep | output | 1 | One-cycle pulse: frame accepted |
| drop | output | 1 | One-cycle pulse: frame rejected |

## Verification
The tests use the exact station address and copies of it with a single bit flipped at either end of the 48 bits. This shows that the comparison covers the full address. Two group addresses whose bins fall in opposite hash words are each tried with only their own bin set, then with only the other word set. This separates a correct word select and bit index from an off-by-one or a swapped word. The all-ones address is sent with the reject control on and off, and with hash words of zero. This shows that broadcast bypasses the hash. Back-to-back random addresses under promiscuous, all-ones-hash and plain settings exercise the pipeline timing against a cycle-accurate reference.

// File: rtl/raf_pkg.sv
package raf_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = ADDR_BYTES * BYTE_W;
    localparam int BIN_W       = 6;
    localparam int WORD_SEL_W  = BIN_W - 1;
    localparam int HASH_WORD_W = 1 << WORD_SEL_W;
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } capture_t;

    typedef struct packed {
        logic             vld;
        logic [BIN_W-1:0] bin;
        logic             is_bcast;
        logic             is_group;
        logic             sta_hit;
    } classify_t;

    typedef struct packed {
        logic keep;
        logic drop;
    } verdict_t;

    typedef struct packed {
        capture_t  cap;
        classify_t cls;
        verdict_t  res;
    } pipe_t;
endpackage

// File: rtl/raf_hash_index.sv
module raf_hash_index
    import raf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [BIN_W-1:0]  bin
);
    logic [CRC_W-1:0] crc_reg;

    // Serial CRC over the address, byte 0 first, each byte LSB first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = CRC_INIT;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            for (int k = 0; k < BYTE_W; k++) begin
                fb = c[0] ^ addr[ADDR_W - BYTE_W * (b + 1) + k];
                c  = c >> 1;
                if (fb) c = c ^ CRC_POLY;
            end
        end
        crc_reg = c;
    end

    // Bin index is the low bits of the reflected register, reversed.
    for (genvar g = 0; g < BIN_W; g++) begin : g_rev
        assign bin[g] = crc_reg[BIN_W - 1 - g];
    end
endmodule

// File: rtl/raf_classify.sv
module raf_classify
    import raf_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CRC_W-1:0]      sta_word_lo,
    input  logic [ADDR_W-CRC_W-1:0] sta_word_hi,
    output logic                  is_bcast,
    output logic                  is_group,
    output logic                  sta_hit
);
    logic [ADDR_W-1:0] station;
    assign station  = {sta_word_hi, sta_word_lo};
    assign is_bcast = &addr;
    assign is_group = addr[ADDR_W - BYTE_W];
    assign sta_hit  = (addr == station);
endmodule

// File: rtl/raf_bin_select.sv
module raf_bin_select
    import raf_pkg::*;
(
    input  logic [BIN_W-1:0]       bin,
    input  logic [HASH_WORD_W-1:0] word_lo,
    input  logic [HASH_WORD_W-1:0] word_hi,
    output logic                   bin_set
);
    logic [HASH_WORD_W-1:0] word;
    assign word    = bin[BIN_W-1] ? word_hi : word_lo;
    assign bin_set = word[bin[WORD_SEL_W-1:0]];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import raf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dst_valid,
    input  logic [47:0] dst_addr,
    input  logic [31:0] sta_word_lo,
    input  logic [15:0] sta_word_hi,
    input  logic [31:0] hash_word_lo,
    input  logic [31:0] hash_word_hi,
    input  logic        bcast_reject,
    input  logic        promisc,
    output logic        keep,
    output logic        drop
);
    pipe_t            pipe_d, pipe_q;
    logic [BIN_W-1:0] bin_w;
    logic             bcast_w, group_w, hit_w, bin_set_w;

    raf_hash_index i_hash (
        .addr (pipe_q.cap.addr),
        .bin  (bin_w)
    );

    raf_classify i_cls (
        .addr        (pipe_q.cap.addr),
        .sta_word_lo (sta_word_lo),
        .sta_word_hi (sta_word_hi),
        .is_bcast    (bcast_w),
        .is_group    (group_w),
        .sta_hit     (hit_w)
    );

    raf_bin_select i_bin (
        .bin     (pipe_q.cls.bin),
        .word_lo (hash_word_lo),
        .word_hi (hash_word_hi),
        .bin_set (bin_set_w)
    );

    always_comb begin
        logic take;
        pipe_d = pipe_q;
        // Stage 1: capture
        pipe_d.cap.vld = dst_valid;
        if (dst_valid) pipe_d.cap.addr = dst_addr;
        // Stage 2: classify and hash
        pipe_d.cls.vld = pipe_q.cap.vld;
        if (pipe_q.cap.vld) begin
            pipe_d.cls.bin      = bin_w;
            pipe_d.cls.is_bcast = bcast_w;
            pipe_d.cls.is_group = group_w;
            pipe_d.cls.sta_hit  = hit_w;
        end
        // Stage 3: decide (broadcast before group, promiscuous over all)
        if (pipe_q.cls.is_bcast)      take = !bcast_reject;
        else if (pipe_q.cls.is_group) take = bin_set_w;
        else                          take = pipe_q.cls.sta_hit;
        take = take | promisc;
        pipe_d.res.keep = pipe_q.cls.vld &  take;
        pipe_d.res.drop = pipe_q.cls.vld & ~take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign keep = pipe_q.res.keep;
    assign drop = pipe_q.res.drop;

    // R7: never both
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(keep && drop));
    // R8: a classified entry yields a result next cycle, and only then
    p_result_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.cls.vld |=> (keep || drop));
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.cls.vld |=> !(keep || drop));
    // R5: promiscuous keeps
    p_promisc_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.cls.vld && promisc) |=> keep);
    // R4: rejected broadcast drops
    p_bcast_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.cls.vld && pipe_q.cls.is_bcast && bcast_reject && !promisc) |=> drop);
    // R2: individual miss drops
    p_station_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.cls.vld && !pipe_q.cls.is_group && !pipe_q.cls.sta_hit && !promisc) |=> drop);
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [31:0] sta_word_lo = 32'h2C3D_4E5F;
    logic [15:0] sta_word_hi = 16'h0A1B;
    logic [31:0] hash_word_lo = '0;
    logic [31:0] hash_word_hi = '0;
    logic        bcast_reject = 1'b0;
    logic        promisc = 1'b0;
    logic        keep, drop;

    int checks = 0;
    int fails  = 0;
    bit active = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk, .rst_n, .dst_valid, .dst_addr, .sta_word_lo, .sta_word_hi,
        .hash_word_lo, .hash_word_hi, .bcast_reject, .promisc, .keep, .drop
    );

    function automatic logic [5:0] ref_bin(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] by = a[47 - 8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic f = c[0] ^ by[j];
                c = c >> 1;
                if (f) c = c ^ 32'hEDB8_8320;
            end
        end
        return {c[0], c[1], c[2], c[3], c[4], c[5]};
    endfunction

    // Reference model, evaluated on the inputs seen at each edge
    logic  e_k1, e_d1, e_k2, e_d2, e_k3, e_d3;
    string t1, t2, t3;
    always @(posedge clk) begin
        logic  k, d, bin_on;
        logic [5:0] bn;
        string t;
        k = 0; d = 0; t = "R8";
        if (dst_valid) begin
            bn = ref_bin(dst_addr);
            bin_on = bn[5] ? hash_word_hi[bn[4:0]] : hash_word_lo[bn[4:0]];
            if (promisc) begin k = 1; t = "R5"; end
            else if (dst_addr == 48'hFFFF_FFFF_FFFF) begin k = !bcast_reject; t = "R4"; end
            else if (dst_addr[40]) begin
                k = bin_on;
                t = (hash_word_lo == '1 && hash_word_hi == '1) ? "R6" : "R3";
            end else begin k = (dst_addr == {sta_word_hi, sta_word_lo}); t = "R2"; end
            d = !k;
        end
        if (!rst_n) begin
            e_k1 <= 0; e_d1 <= 0; e_k2 <= 0; e_d2 <= 0; e_k3 <= 0; e_d3 <= 0;
        end else begin
            e_k1 <= k; e_d1 <= d; t1 <= t;
            e_k2 <= e_k1; e_d2 <= e_d1; t2 <= t1;
            e_k3 <= e_k2; e_d3 <= e_d2; t3 <= t2;
        end
    end

    always @(negedge clk) begin
        if (active) begin
            checks++;
            if (keep !== e_k3 || drop !== e_d3) begin
                fails++;
                $display("FAIL %s: keep/drop=%b%b expected %b%b", t3, keep, drop, e_k3, e_d3);
            end
            checks++;
            if (keep && drop) begin
                fails++;
                $display("FAIL R7: keep/drop=%b%b expected not both", keep, drop);
            end
        end
    end

    task automatic drive(input logic v, input logic [47:0] a);
        @(negedge clk);
        dst_valid = v;
        dst_addr  = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R8: watchdog expired, run incomplete expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] g_lo, g_hi, a;
        logic [5:0]  b_lo, b_hi;
        bit f_lo, f_hi;
        f_lo = 0; f_hi = 0; g_lo = '0; g_hi = '0; b_lo = '0; b_hi = '0;
        for (int k = 0; k < 256; k++) begin
            a = {8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, k[7:0]};
            if (!ref_bin(a)[5] && !f_lo) begin g_lo = a; b_lo = ref_bin(a); f_lo = 1; end
            if ( ref_bin(a)[5] && !f_hi) begin g_hi = a; b_hi = ref_bin(a); f_hi = 1; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R1 reset state
        if (keep !== 1'b0 || drop !== 1'b0) begin
            fails++;
            $display("FAIL R1: keep/drop=%b%b expected 00", keep, drop);
        end
        active = 1'b1;

        // R2: exact station and single-bit misses
        drive(1, 48'h0A1B_2C3D_4E5F);
        drive(1, 48'h0A1B_2C3D_4E5E);
        drive(1, 48'h8A1B_2C3D_4E5F);
        drive(1, 48'h0A1B_2C3D_4E5F);
        idle(4);

        // R3: bins in each word, own bit vs other word
        hash_word_lo = 32'h1 << b_lo[4:0];
        drive(1, g_lo); drive(1, g_hi); idle(4);
        hash_word_lo = '0; hash_word_hi = 32'h1 << b_hi[4:0];
        drive(1, g_hi); drive(1, g_lo); idle(4);
        hash_word_lo = 32'h1 << b_hi[4:0]; hash_word_hi = '0;
        drive(1, g_hi); idle(4);

        // R4: broadcast with hash empty, reject off then on
        hash_word_lo = '0;
        drive(1, 48'hFFFF_FFFF_FFFF); idle(4);
        bcast_reject = 1;
        drive(1, 48'hFFFF_FFFF_FFFF); idle(4);
        hash_word_lo = '1; hash_word_hi = '1;
        drive(1, 48'hFFFF_FFFF_FFFF); idle(4);

        // R6: all bins set, random group addresses back to back
        for (int i = 0; i < 40; i++) drive(1, {$urandom, $urandom} | 48'h0100_0000_0000);
        idle(4);

        // R5: promiscuous, mixed random back to back
        promisc = 1;
        hash_word_lo = '0; hash_word_hi = '0;
        for (int i = 0; i < 40; i++) drive(1, {$urandom, $urandom});
        drive(1, 48'hFFFF_FFFF_FFFF);
        idle(4);

        // R8/R2/R3: plain mode, random with gaps, sparse hash
        promisc = 0; bcast_reject = 0;
        hash_word_lo = 32'hA5A5_0F0F; hash_word_hi = 32'h3C3C_F00F;
        for (int i = 0; i < 200; i++) drive($urandom_range(0, 1), {$urandom, $urandom});
        idle(4);

        active = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule